// File: doc/BRIEF.md
# Interface Activity Detector and Power Arbiter

This block decides which of two video input paths owns a shared output stage and which parts of the chip stay powered. It watches three sync lines of the analog path (horizontal sync, vertical sync, sync-on-green) and two signals of the digital link: a toggling clock-presence indicator and a data-enable strobe. Each watched line has its own activity flag. A flag sets on any edge and clears when a slow reference tick has pulsed a set number of times with no edge in between. The timeout is a parameter. At the chip's tick rate it is sized to flag a lost signal within 100 ms, and simulation uses a few ticks.

Digital detection works in two steps. While the link clock is active, the receiver is enabled for probing. A qualifier then counts data-enable rising edges that follow each other closely. The link counts as locked on the 32nd such edge. A missing edge or a lost clock sends the count back to zero.

A registered arbiter resolves the operating mode, highest priority first: the power bit, then the override bit, then automatic detection. When both paths are detected, the select bit decides. The arbiter drives the analog path enable, the digital receiver enable, a sense enable (bandgap, sync detector and clock detector) and a chip-active flag.

Top module: `ifc_power_arbiter`

## Requirements
- R1: An edge of either direction on `hsync_in`, `vsync_in` or `sog_in` sets that line's own activity flag at the next clock edge. The analog path counts as detected when any of these three flags is set.
- R2: An activity flag stays set through TMO_TICKS-1 cycles with `tick` high and no edge on its line. It clears on the TMO_TICKS-th such tick.
- R3: `lclk_in` has an activity monitor that behaves in the same way. It runs in every mode except power-off, whichever path is selected.
- R4: While the link clock flag is set, `de_locked` rises at the clock edge that samples the DE_NEED-th (32 by default) rising edge of `de_in`, where each rising edge comes less than DE_GAP cycles after the previous one. It stays high while such edges keep arriving.
- R5: If DE_GAP cycles pass with no rising edge of `de_in`, or the link clock flag clears, the pulse count returns to zero and `de_locked` drops. A fresh run of DE_NEED rising edges is then needed to lock again.
- R6: With `pwr_on` low, `mode` becomes 0 (power-off) one cycle later, whatever the override bit says. All activity flags and `de_locked` clear, and `sense_en`, `ana_pwr_en`, `dig_pwr_en` and `chip_active` are low.
- R7: With `pwr_on` high and `ovr_en` high, `mode` one cycle later is 3 (digital) if `ovr_sel` is 1 and 2 (analog) if it is 0, whatever is detected.
- R8: With `pwr_on` high and `ovr_en` low, the mode is chosen from detection:
  - only analog detected gives 2;
  - only digital detected (link clock flag and `de_locked` both set) gives 3;
  - both detected gives 3 if `ovr_sel` is 1 and 2 otherwise;
  - neither gives 1 (seek), with `chip_active` low.
- R9: The outputs follow the mode:
  - `ana_pwr_en` is high only in mode 2;
  - `dig_pwr_en` is high in mode 3, and in mode 1 while the link clock flag is set;
  - `sense_en` is high in every mode except 0;
  - `chip_active` is high in modes 2 and 3.
- R10: After reset with `pwr_on` high and no activity, the mode is 1, every flag is clear and `sense_en` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Slow reference tick, one cycle wide |
| hsync_in | input | 1 | Horizontal sync, synchronous to clk |
| vsync_in | input | 1 | Vertical sync, synchronous to clk |
| sog_in | input | 1 | Sync-on-green slicer output |
| lclk_in | input | 1 | Toggling indicator of the digital link clock |
| de_in | input | 1 | Digital link data-enable strobe |
| pwr_on | input | 1 | 0 forces power-off |
| ovr_en | input | 1 | 1 selects the path from `ovr_sel` |
| ovr_sel | input | 1 | Path choice or tie-break: 0 analog, 1 digital |
| act_hs | output | 1 | Horizontal sync activity flag |
| act_vs | output | 1 | Vertical sync activity flag |
| act_sog | output | 1 | Sync-on-green activity flag |
| act_lclk | output | 1 | Link clock activity flag |
| de_locked | output | 1 | Data-enable qualifier locked |
| mode | output | 2 | 0 off, 1 seek, 2 analog, 3 digital |
| ana_pwr_en | output | 1 | Analog path enable |
| dig_pwr_en | output | 1 | Digital receiver enable |
| sense_en | output | 1 | Bandgap, sync detector and clock detector enable |
| chip_active | output | 1 | One path owns the outputs |

## Verification
The assertions assume that every input is already synchronous to `clk` and that `tick` is high for single cycles only. They also assume that the mode register settles only after the internal reset release, so the checker is tied to the synchronised reset. The stimulus changes all inputs on the falling clock edge. Sync lines and the link indicator toggle every few cycles, well inside the tick timeout. Data-enable pulses repeat every four cycles, inside the gap window, except where a gap or a clock loss is created on purpose. Random choices of override and select are made only while the detection state is known: both paths active, or neither.

// File: rtl/ifc_pkg.sv
package ifc_pkg;
  typedef enum logic [1:0] {
    MODE_OFF  = 2'd0,
    MODE_SEEK = 2'd1,
    MODE_ANA  = 2'd2,
    MODE_DIG  = 2'd3
  } mode_e;

  localparam int NUM_MON = 4;  // hs, vs, sog, link clock

  function automatic mode_e pick_mode(input logic pwr, input logic ovr,
                                      input logic sel, input logic ana,
                                      input logic dig);
    mode_e m;
    if (!pwr)            m = MODE_OFF;
    else if (ovr)        m = sel ? MODE_DIG : MODE_ANA;
    else if (ana && dig) m = sel ? MODE_DIG : MODE_ANA;
    else if (ana)        m = MODE_ANA;
    else if (dig)        m = MODE_DIG;
    else                 m = MODE_SEEK;
    return m;
  endfunction
endpackage

// File: rtl/ifc_activity_mon.sv
module ifc_activity_mon #(
  parameter int TMO_TICKS = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic tick,
  input  logic sig,
  output logic active
);
  localparam int CW = $clog2(TMO_TICKS + 1);
  localparam logic [CW-1:0] LAST = CW'(TMO_TICKS - 1);

  logic          prev_q, prev_d;
  logic          act_q, act_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          edge_seen;

  assign edge_seen = sig ^ prev_q;

  always_comb begin
    prev_d = sig;
    act_d  = act_q;
    cnt_d  = cnt_q;
    if (!en) begin
      act_d = 1'b0;
      cnt_d = '0;
    end else if (edge_seen) begin
      act_d = 1'b1;
      cnt_d = '0;
    end else if (tick && act_q) begin
      if (cnt_q == LAST) begin
        act_d = 1'b0;
        cnt_d = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      act_q  <= 1'b0;
      cnt_q  <= '0;
    end else begin
      prev_q <= prev_d;
      act_q  <= act_d;
      cnt_q  <= cnt_d;
    end
  end

  assign active = act_q;
endmodule

// File: rtl/ifc_de_qualifier.sv
module ifc_de_qualifier #(
  parameter int DE_NEED = 32,
  parameter int DE_GAP  = 4096
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic clk_act,
  input  logic de,
  output logic locked
);
  localparam int CW = $clog2(DE_NEED + 1);
  localparam int GW = $clog2(DE_GAP + 1);
  localparam logic [CW-1:0] NEED_LAST = CW'(DE_NEED - 1);
  localparam logic [GW-1:0] GAP_LAST  = GW'(DE_GAP - 1);

  logic          de_prev_q;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [GW-1:0] gap_q, gap_d;
  logic          lock_q, lock_d;
  logic          rise, armed;

  assign rise  = de & ~de_prev_q;
  assign armed = (cnt_q != '0) | lock_q;

  always_comb begin
    cnt_d  = cnt_q;
    gap_d  = gap_q;
    lock_d = lock_q;
    if (!en || !clk_act) begin
      cnt_d  = '0;
      gap_d  = '0;
      lock_d = 1'b0;
    end else if (rise) begin
      gap_d = '0;
      if (cnt_q == NEED_LAST || lock_q) lock_d = 1'b1;
      else                               cnt_d  = cnt_q + 1'b1;
    end else if (armed) begin
      if (gap_q == GAP_LAST) begin
        cnt_d  = '0;
        gap_d  = '0;
        lock_d = 1'b0;
      end else begin
        gap_d = gap_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      de_prev_q <= 1'b0;
      cnt_q     <= '0;
      gap_q     <= '0;
      lock_q    <= 1'b0;
    end else begin
      de_prev_q <= de;
      cnt_q     <= cnt_d;
      gap_q     <= gap_d;
      lock_q    <= lock_d;
    end
  end

  assign locked = lock_q;
endmodule

// File: rtl/ifc_mode_arbiter.sv
module ifc_mode_arbiter
  import ifc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pwr_on,
  input  logic       ovr_en,
  input  logic       ovr_sel,
  input  logic       ana_det,
  input  logic       dig_det,
  input  logic       lclk_act,
  output logic [1:0] mode,
  output logic       ana_pwr_en,
  output logic       dig_pwr_en,
  output logic       sense_en,
  output logic       chip_active
);
  mode_e mode_q, mode_d;

  always_comb mode_d = pick_mode(pwr_on, ovr_en, ovr_sel, ana_det, dig_det);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= MODE_OFF;
    else        mode_q <= mode_d;
  end

  always_comb begin
    mode        = mode_q;
    ana_pwr_en  = (mode_q == MODE_ANA);
    dig_pwr_en  = (mode_q == MODE_DIG) || ((mode_q == MODE_SEEK) && lclk_act);
    sense_en    = (mode_q != MODE_OFF);
    chip_active = (mode_q == MODE_ANA) || (mode_q == MODE_DIG);
  end
endmodule

// File: rtl/ifc_power_arbiter.sv
module ifc_power_arbiter
  import ifc_pkg::*;
#(
  parameter int TMO_TICKS = 1000,
  parameter int DE_NEED   = 32,
  parameter int DE_GAP    = 4096
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       hsync_in,
  input  logic       vsync_in,
  input  logic       sog_in,
  input  logic       lclk_in,
  input  logic       de_in,
  input  logic       pwr_on,
  input  logic       ovr_en,
  input  logic       ovr_sel,
  output logic       act_hs,
  output logic       act_vs,
  output logic       act_sog,
  output logic       act_lclk,
  output logic       de_locked,
  output logic [1:0] mode,
  output logic       ana_pwr_en,
  output logic       dig_pwr_en,
  output logic       sense_en,
  output logic       chip_active
);
  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  logic [NUM_MON-1:0] mon_in, mon_act;
  assign mon_in = {lclk_in, sog_in, vsync_in, hsync_in};

  for (genvar i = 0; i < NUM_MON; i++) begin : g_mon
    ifc_activity_mon #(.TMO_TICKS(TMO_TICKS)) u_mon (
      .clk    (clk),
      .rst_n  (rst_sync_n),
      .en     (pwr_on),
      .tick   (tick),
      .sig    (mon_in[i]),
      .active (mon_act[i])
    );
  end

  ifc_de_qualifier #(.DE_NEED(DE_NEED), .DE_GAP(DE_GAP)) u_deq (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .en      (pwr_on),
    .clk_act (mon_act[3]),
    .de      (de_in),
    .locked  (de_locked)
  );

  logic ana_det, dig_det;
  assign ana_det = |mon_act[2:0];
  assign dig_det = mon_act[3] & de_locked;

  ifc_mode_arbiter u_arb (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .pwr_on      (pwr_on),
    .ovr_en      (ovr_en),
    .ovr_sel     (ovr_sel),
    .ana_det     (ana_det),
    .dig_det     (dig_det),
    .lclk_act    (mon_act[3]),
    .mode        (mode),
    .ana_pwr_en  (ana_pwr_en),
    .dig_pwr_en  (dig_pwr_en),
    .sense_en    (sense_en),
    .chip_active (chip_active)
  );

  assign act_hs   = mon_act[0];
  assign act_vs   = mon_act[1];
  assign act_sog  = mon_act[2];
  assign act_lclk = mon_act[3];
endmodule

// File: rtl/ifc_power_arbiter_chk.sv
module ifc_power_arbiter_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       de_in,
  input logic       pwr_on,
  input logic       ovr_en,
  input logic       ovr_sel,
  input logic       act_hs,
  input logic       act_vs,
  input logic       act_sog,
  input logic       act_lclk,
  input logic       de_locked,
  input logic [1:0] mode,
  input logic       ana_pwr_en,
  input logic       dig_pwr_en,
  input logic       chip_active
);
  a_r6_off_next: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_on |=> mode == 2'd0);

  a_r6_flags_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_on |=> !(act_hs || act_vs || act_sog || act_lclk || de_locked));

  a_r7_override: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_on && ovr_en) |=> mode == {1'b1, $past(ovr_sel)});

  a_r8_seek: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_on && !ovr_en && !act_hs && !act_vs && !act_sog && !(act_lclk && de_locked))
      |=> mode == 2'd1);

  a_r9_one_path: assert property (@(posedge clk) disable iff (!rst_n)
    chip_active |-> $countones({ana_pwr_en, dig_pwr_en}) == 1);

  a_r5_clk_loss: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(act_lclk) |=> !de_locked);

  a_r4_lock_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(de_locked) |-> ($past(de_in) && !$past(de_in, 2)));
endmodule

bind ifc_power_arbiter ifc_power_arbiter_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .de_in       (de_in),
  .pwr_on      (pwr_on),
  .ovr_en      (ovr_en),
  .ovr_sel     (ovr_sel),
  .act_hs      (act_hs),
  .act_vs      (act_vs),
  .act_sog     (act_sog),
  .act_lclk    (act_lclk),
  .de_locked   (de_locked),
  .mode        (mode),
  .ana_pwr_en  (ana_pwr_en),
  .dig_pwr_en  (dig_pwr_en),
  .chip_active (chip_active)
);

// File: tb/ifc_power_arbiter_test.sv
`timescale 1ns/1ps
module ifc_power_arbiter_test;
  localparam int TMO = 4;
  localparam int NEED = 32;
  localparam int GAP = 16;

  logic clk = 1'b0;
  logic rst_n, tick, hsync_in, vsync_in, sog_in, lclk_in, de_in;
  logic pwr_on, ovr_en, ovr_sel;
  logic act_hs, act_vs, act_sog, act_lclk, de_locked;
  logic [1:0] mode;
  logic ana_pwr_en, dig_pwr_en, sense_en, chip_active;

  int total = 0;
  int bad = 0;
  bit hs_run = 0, lclk_run = 0, de_run = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  ifc_power_arbiter #(.TMO_TICKS(TMO), .DE_NEED(NEED), .DE_GAP(GAP)) uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .hsync_in(hsync_in),
    .vsync_in(vsync_in), .sog_in(sog_in), .lclk_in(lclk_in), .de_in(de_in),
    .pwr_on(pwr_on), .ovr_en(ovr_en), .ovr_sel(ovr_sel),
    .act_hs(act_hs), .act_vs(act_vs), .act_sog(act_sog), .act_lclk(act_lclk),
    .de_locked(de_locked), .mode(mode), .ana_pwr_en(ana_pwr_en),
    .dig_pwr_en(dig_pwr_en), .sense_en(sense_en), .chip_active(chip_active)
  );

  // expected mode from the requirements: 0 off, 1 seek, 2 analog, 3 digital
  function automatic logic [1:0] exp_mode(bit pwr, bit ovr, bit sel, bit ana, bit dig);
    if (!pwr) return 2'd0;
    if (ovr) return sel ? 2'd3 : 2'd2;
    if (ana && dig) return sel ? 2'd3 : 2'd2;
    if (ana) return 2'd2;
    if (dig) return 2'd3;
    return 2'd1;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic tick_pulse();
    @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
  endtask

  task automatic de_pulses(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) de_in = 1'b1;
      @(negedge clk) de_in = 1'b0;
      cyc(2);
    end
  endtask

  task automatic sync_edge(int which);
    @(negedge clk);
    if (which == 1) vsync_in = ~vsync_in;
    else            sog_in   = ~sog_in;
    cyc(2);
  endtask

  // background activity sources
  initial begin
    int ph = 0;
    forever begin
      @(negedge clk);
      if (hs_run) begin
        ph = (ph + 1) % 4;
        if (ph == 0) hsync_in = ~hsync_in;
      end
    end
  end

  initial forever begin
    @(negedge clk);
    if (lclk_run) lclk_in = ~lclk_in;
  end

  initial begin
    int ph = 0;
    forever begin
      @(negedge clk);
      if (de_run) begin
        ph = (ph + 1) % 4;
        de_in = (ph == 0);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    rst_n = 0; tick = 0; hsync_in = 0; vsync_in = 0; sog_in = 0;
    lclk_in = 0; de_in = 0; pwr_on = 1; ovr_en = 0; ovr_sel = 0;
    cyc(4);
    rst_n = 1;
    cyc(5);
    // R10 reset state
    chk("R10 mode", mode, 1);
    chk("R10 flags", {act_hs, act_vs, act_sog, act_lclk, de_locked}, 0);
    chk("R10 sense_en", sense_en, 1);
    chk("R10 chip_active", chip_active, 0);
    chk("R9 seek enables", {ana_pwr_en, dig_pwr_en}, 0);

    // R1 horizontal sync activity -> analog
    hs_run = 1;
    cyc(8);
    chk("R1 act_hs", act_hs, 1);
    chk("R8 analog only", mode, exp_mode(1, 0, 0, 1, 0));
    chk("R9 analog enables", {ana_pwr_en, dig_pwr_en, chip_active}, 3'b101);

    // R2 timeout
    hs_run = 0;
    cyc(6);
    repeat (TMO - 1) tick_pulse();
    chk("R2 still active", act_hs, 1);
    tick_pulse();
    chk("R2 cleared", act_hs, 0);
    cyc(1);
    chk("R8 back to seek", mode, 1);
    chk("R8 chip inactive", chip_active, 0);

    // R1 vsync and sync-on-green alone
    sync_edge(1);
    chk("R1 act_vs", act_vs, 1);
    chk("R1 vs gives analog", mode, 2);
    repeat (TMO) tick_pulse();
    chk("R2 vs cleared", act_vs, 0);
    sync_edge(2);
    chk("R1 act_sog", act_sog, 1);
    chk("R1 sog gives analog", mode, 2);
    repeat (TMO) tick_pulse();
    cyc(1);
    chk("R2 sog cleared", act_sog, 0);

    // R3 link clock, seek probing
    lclk_run = 1;
    cyc(4);
    chk("R3 act_lclk", act_lclk, 1);
    chk("R3 mode seek", mode, 1);
    chk("R9 probe enable", dig_pwr_en, 1);

    // R4 lock on the 32nd pulse
    de_pulses(NEED - 1);
    chk("R4 not yet", de_locked, 0);
    de_pulses(1);
    chk("R4 locked", de_locked, 1);
    chk("R8 digital only", mode, 3);
    chk("R9 digital enables", {ana_pwr_en, dig_pwr_en, chip_active}, 3'b011);

    // R5 gap clears count
    cyc(GAP + 4);
    chk("R5 gap unlock", de_locked, 0);
    chk("R5 gap seek", mode, 1);
    de_pulses(NEED - 1);
    chk("R5 count restarted", de_locked, 0);
    de_pulses(1);
    chk("R5 relock", de_locked, 1);
    de_run = 1;
    cyc(40);
    chk("R4 held", de_locked, 1);

    // R5 clock loss
    lclk_run = 0;
    repeat (TMO) tick_pulse();
    cyc(1);
    chk("R3 lclk lost", act_lclk, 0);
    chk("R5 clock loss unlock", de_locked, 0);

    // R8 both detected, tie broken by select
    de_run = 0;
    @(negedge clk) de_in = 0;
    hs_run = 1; lclk_run = 1;
    cyc(6);
    de_pulses(NEED);
    de_run = 1;
    ovr_sel = 0;
    cyc(3);
    chk("R8 both sel0", mode, 2);
    ovr_sel = 1;
    cyc(2);
    chk("R8 both sel1", mode, 3);
    for (int i = 0; i < 24; i++) begin
      ovr_en  = 1'($urandom % 2);
      ovr_sel = 1'($urandom % 2);
      cyc(2);
      chk("R8 random both", mode, exp_mode(1, ovr_en, ovr_sel, 1, 1));
    end

    // R7 override with nothing detected
    ovr_en = 0;
    hs_run = 0; lclk_run = 0; de_run = 0;
    @(negedge clk) de_in = 0;
    repeat (TMO + 1) tick_pulse();
    cyc(GAP + 2);
    chk("R8 none seek", mode, 1);
    for (int i = 0; i < 24; i++) begin
      ovr_en  = 1'($urandom % 2);
      ovr_sel = 1'($urandom % 2);
      cyc(2);
      chk("R7 random idle", mode, exp_mode(1, ovr_en, ovr_sel, 0, 0));
    end
    ovr_en = 1; ovr_sel = 1;
    cyc(2);
    chk("R7 override digital", mode, 3);
    chk("R7 chip active", chip_active, 1);
    ovr_sel = 0;
    cyc(2);
    chk("R7 override analog", mode, 2);

    // R6 power-off beats override
    hs_run = 1; ovr_sel = 1;
    cyc(8);
    pwr_on = 0;
    cyc(2);
    chk("R6 mode off", mode, 0);
    chk("R6 flags clear", {act_hs, act_vs, act_sog, act_lclk, de_locked}, 0);
    chk("R6 enables low", {sense_en, ana_pwr_en, dig_pwr_en, chip_active}, 0);
    pwr_on = 1;
    cyc(3);
    chk("R7 after power", mode, 3);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule